// File: doc/BRIEF.md
# Sliding-Window Bit Autocorrelation Counter

This block keeps a running autocorrelation matrix of antipodal user bits for a multiuser channel estimator. Each update supplies a vector of 2K one-bit symbols. The first K bits belong to the K users at the current bit time, and the next K bits to the same users one bit time earlier. The update also supplies the vector that is leaving a window of L bit intervals. For every pair of entries, the product of the new vector is added to the stored matrix element and the product of the leaving vector is taken away.

The design uses no multipliers. Two antipodal bits multiply to a single XNOR, and each matrix element is a small signed counter that moves by at most two per update. One element is updated per clock cycle. An accepted load strobe starts a sweep over all 4K² elements, and a done pulse marks the end of the sweep. A registered read port returns any single element when the block is idle.

Top module: `bitcorr_window`

## Requirements
- R1: After a synchronous reset every element reads 0, and busy and done are low.
- R2: Bit value 1 stands for +1 and 0 stands for -1. Vector bit j (j < K) is user j at the current time, and bit K+j is user j at the previous time. The element at address r*2K+c gains +1 when bits r and c of the new vector are equal and -1 when they differ.
- R3: Each diagonal element counts accepted updates up to L and then holds at L.
- R4: During the first L accepted updates after reset, the departing vector has no effect on any element.
- R5: From update L+1 onward, the departing vector's product is subtracted from every element, so an element equals the sum of the products of the last L new vectors.
- R6: A load seen while idle is accepted. Busy is then high for exactly 4K² cycles, and one element is written per cycle.
- R7: Done is a single-cycle pulse in the first cycle after busy falls.
- R8: A load strobe while busy is ignored. It neither restarts the sweep nor adds an update.
- R9: The element selected by the read address appears on the read data one cycle later.
- R10: Element (r,c) equals element (c,r) after every completed update.
- R11: With a consistent sliding window, no element ever leaves the range -L to +L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Update start strobe |
| cur_bits_i | input | 2K | New bit vector (current time users, then previous time users) |
| out_bits_i | input | 2K | Bit vector leaving the window |
| rd_addr_i | input | clog2(4K²) | Element address r*2K+c |
| rd_data_o | output | 1+clog2(L+1) | Signed element value, registered |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse at sweep end |

## Verification
The hardest point to reach is the hand-over at update L+1, where the departing vector starts to count after being ignored. The stimulus fills the window with departing vectors that do not match the history, so any early subtraction would show up at once, especially on the diagonal. It then feeds true window history so that subtraction takes over. A second hard point is a load strobe raised in the middle of a sweep. The bench raises this strobe partway through busy and then checks the sweep length and every element against the model.

// File: rtl/bitcorr_pkg.sv
package bitcorr_pkg;
  // product of two antipodal bits: 1 encodes +1, 0 encodes -1
  function automatic logic sign_prod(input logic a, input logic b);
    return a ~^ b;
  endfunction

  // step contribution of one product term
  function automatic logic signed [2:0] term_step(input logic agree, input logic negate);
    logic signed [2:0] s;
    s = agree ? 3'sd1 : -3'sd1;
    return negate ? -s : s;
  endfunction
endpackage

// File: rtl/bitcorr_seq.sv
module bitcorr_seq #(
  parameter int N = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_i,
  output logic                        start_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [$clog2(N*N)-1:0]      idx_o,
  output logic [$clog2(N)-1:0]        row_o,
  output logic [$clog2(N)-1:0]        col_o
);
  localparam int M  = N * N;
  localparam int AW = $clog2(M);
  localparam int RW = $clog2(N);

  logic          busy_q, done_q;
  logic [AW-1:0] idx_q;
  logic [RW-1:0] row_q, col_q;
  logic          last;

  assign last    = (idx_q == AW'(M - 1));
  assign start_o = load_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        row_q  <= '0;
        col_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          if (col_q == RW'(N - 1)) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign row_o  = row_q;
  assign col_o  = col_q;

  // R7: the last element write is followed by done and idle
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && last) |=> (done_q && !busy_q));
  // R7: done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8: a sweep keeps stepping whatever load does
  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> (busy_q && idx_q == AW'($past(idx_q) + 1'b1)));
  // R2: linear address agrees with the row/column counters
  assert_addr_map_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (int'(idx_q) == int'(row_q) * N + int'(col_q)));
endmodule

// File: rtl/bitcorr_delta.sv
module bitcorr_delta #(
  parameter int N = 4
) (
  input  logic [N-1:0]          cur_bits_i,
  input  logic [N-1:0]          old_bits_i,
  input  logic                  sub_en_i,
  input  logic [$clog2(N)-1:0]  row_i,
  input  logic [$clog2(N)-1:0]  col_i,
  output logic signed [2:0]     delta_o
);
  import bitcorr_pkg::*;

  logic new_agree, old_agree;
  logic signed [2:0] add_term, sub_term;

  assign new_agree = sign_prod(cur_bits_i[row_i], cur_bits_i[col_i]);
  assign old_agree = sign_prod(old_bits_i[row_i], old_bits_i[col_i]);
  assign add_term  = term_step(new_agree, 1'b0);
  assign sub_term  = sub_en_i ? term_step(old_agree, 1'b1) : 3'sd0;
  assign delta_o   = add_term + sub_term;
endmodule

// File: rtl/bitcorr_bank.sv
module bitcorr_bank #(
  parameter int DEPTH = 16,
  parameter int W     = 5,
  parameter int L     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_i,
  input  logic [$clog2(DEPTH)-1:0]   waddr_i,
  input  logic signed [2:0]          delta_i,
  input  logic [$clog2(DEPTH)-1:0]   raddr_i,
  output logic signed [W-1:0]        rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic signed [W-1:0] mem [DEPTH];
  logic signed [W-1:0] rdata_q;
  logic signed [W:0]   sum;

  assign sum = {mem[waddr_i][W-1], mem[waddr_i]} + (W+1)'(delta_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) mem[waddr_i] <= sum[W-1:0];
      rdata_q <= mem[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

  // R11: a counter never steps outside the window range
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    we_i |-> (sum <= (W+1)'(L) && sum >= -(W+1)'(L)));
endmodule

// File: rtl/bitcorr_window.sv
module bitcorr_window #(
  parameter int K  = 2,
  parameter int L  = 8,
  localparam int N  = 2 * K,
  localparam int M  = N * N,
  localparam int AW = $clog2(M),
  localparam int FW = $clog2(L + 1),
  localparam int W  = 1 + FW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [N-1:0]         cur_bits_i,
  input  logic [N-1:0]         out_bits_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic signed [W-1:0]  rd_data_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int RW = $clog2(N);

  logic          start, busy, done;
  logic [AW-1:0] idx;
  logic [RW-1:0] row, col;
  logic [N-1:0]  cur_q, old_q;
  logic          sub_q;
  logic [FW-1:0] fill_q;
  logic signed [2:0] delta;

  bitcorr_seq #(.N(N)) u_seq (
    .clk(clk), .rst(rst), .load_i(load_i), .start_o(start),
    .busy_o(busy), .done_o(done), .idx_o(idx), .row_o(row), .col_o(col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      old_q  <= '0;
      sub_q  <= 1'b0;
      fill_q <= '0;
    end else if (start) begin
      cur_q <= cur_bits_i;
      old_q <= out_bits_i;
      sub_q <= (fill_q == FW'(L));
      if (fill_q != FW'(L)) fill_q <= fill_q + 1'b1;
    end
  end

  bitcorr_delta #(.N(N)) u_delta (
    .cur_bits_i(cur_q), .old_bits_i(old_q), .sub_en_i(sub_q),
    .row_i(row), .col_i(col), .delta_o(delta)
  );

  bitcorr_bank #(.DEPTH(M), .W(W), .L(L)) u_bank (
    .clk(clk), .rst(rst), .we_i(busy), .waddr_i(idx), .delta_i(delta),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  assign busy_o = busy;
  assign done_o = done;

  // R4: no subtraction while the window is still filling
  assert_no_early_sub_R4: assert property (@(posedge clk) disable iff (rst)
    (start && fill_q != FW'(L)) |=> !sub_q);
  // R5: subtraction once the window is full
  assert_sub_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (start && fill_q == FW'(L)) |=> sub_q);
  // R3: a diagonal element never decreases
  assert_diag_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && row == col) |-> (delta == 3'sd1 || delta == 3'sd0));
endmodule

// File: tb/bitcorr_window_bench.sv
module bitcorr_window_bench;
  localparam int K  = 2;
  localparam int L  = 8;
  localparam int N  = 2 * K;
  localparam int M  = N * N;
  localparam int AW = $clog2(M);
  localparam int W  = 1 + $clog2(L + 1);
  localparam int NV = 12;
  // upper nibble: new vector, lower nibble: junk departing vector
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h96, 8'h5A,
                                      8'hC3, 8'h71, 8'hE8, 8'h2D, 8'hB4, 8'h4B};

  logic clk = 1'b0, rst = 1'b1, load = 1'b0;
  logic [N-1:0] cur_bits = '0, out_bits = '0;
  logic [AW-1:0] rd_addr = '0;
  logic signed [W-1:0] rd_data;
  logic busy, done;

  int ntot = 0, nfail = 0, fill = 0;
  int model [M];
  logic [N-1:0] hist [NV];

  always #10 clk = ~clk;

  bitcorr_window #(.K(K), .L(L)) u_bitcorr_window (
    .clk(clk), .rst(rst), .load_i(load), .cur_bits_i(cur_bits),
    .out_bits_i(out_bits), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk) rd_addr = AW'(a);
    @(negedge clk) v = int'(rd_data);
  endtask

  task automatic model_upd(input logic [N-1:0] nb, input logic [N-1:0] ob);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        model[r*N+c] += (nb[r] == nb[c]) ? 1 : -1;
        if (fill >= L) model[r*N+c] -= (ob[r] == ob[c]) ? 1 : -1;
      end
    if (fill < L) fill++;
  endtask

  task automatic run_update(input logic [N-1:0] nb, input logic [N-1:0] ob, input bit inject);
    int cnt;
    @(negedge clk) begin load = 1'b1; cur_bits = nb; out_bits = ob; end
    @(negedge clk) load = 1'b0;
    cnt = 0;
    while (busy && cnt < 4 * M) begin
      cnt++;
      if (inject && cnt == 3) begin load = 1'b1; cur_bits = ~nb; out_bits = nb; end
      else load = 1'b0;
      @(negedge clk);
    end
    load = 1'b0;
    chk(cnt == M, inject ? "R8 sweep length with load in busy" : "R6 busy length", cnt, M);
    chk(done == 1'b1, "R7 done at end", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7/R8 done single, no restart", int'({busy, done}), 0);
    model_upd(nb, ob);
  endtask

  task automatic check_all(input string req);
    int v [M];
    for (int a = 0; a < M; a++) begin
      rd(a, v[a]);
      chk(v[a] == model[a], req, v[a], model[a]);
      chk(v[a] <= L && v[a] >= -L, "R11 range", v[a], L);
    end
    for (int r = 0; r < N; r++) begin
      chk(v[r*N+r] == fill, "R3 diagonal count", v[r*N+r], fill);
      for (int c = r + 1; c < N; c++)
        chk(v[r*N+c] == v[c*N+r], "R10 symmetry", v[r*N+c], v[c*N+r]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R6 watchdog act=hung exp=finished");
    ntot++; nfail++;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    int v;
    for (int a = 0; a < M; a++) model[a] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);
    for (int a = 0; a < M; a++) begin
      rd(a, v);
      chk(v == 0, "R1 zero element", v, 0);
    end
    // R9: read latency, address changes and data follows one cycle later
    @(negedge clk) rd_addr = AW'(1);
    @(negedge clk) rd_addr = AW'(2);
    chk(int'(rd_data) == 0, "R9 read latency", int'(rd_data), 0);

    // table walk: R2 and R4 in the filling phase, R5 once full
    for (int i = 0; i < NV; i++) begin
      logic [N-1:0] nb, ob;
      nb = VEC[i][7:4];
      ob = (i >= L) ? hist[i-L] : VEC[i][3:0];
      hist[i] = nb;
      run_update(nb, ob, 1'b0);
      check_all(i < L ? "R2/R4 element while filling" : "R5 element with subtraction");
    end

    // R8: load strobe in the middle of a sweep
    run_update(4'b0110, hist[NV-L], 1'b0);
    run_update(4'b1011, hist[NV-L+1], 1'b1);
    check_all("R8 element after ignored load");

    // R1/R4: reset mid-life, then first update ignores departing vector
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int a = 0; a < M; a++) model[a] = 0;
    fill = 0;
    check_all("R1 element after reset");
    run_update(4'b1001, 4'b0101, 1'b0);
    check_all("R4 departing ignored after reset");

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule